// File: doc/BRIEF.md
# Dual Byte FIFO with Per-Lane Direction

This block holds two independent byte FIFOs, four entries each by default, placed between a system bus port and an internal datapath. A per-lane direction bit decides which side fills a lane and which side drains it. In inbound mode the bus fills the lane and the datapath drains it. In outbound mode the datapath fills the lane and the bus drains it. Bus accesses pick a lane with a one-bit select. The datapath has a write strobe and a read strobe for each lane.

A capture strobe loads both lanes in one cycle, taking one datapath byte for lane 0 and another for lane 1. This lets two accumulator values be stored as a pair. The block exports per-lane empty, full and service-request flags, which can drive a sequencer, an interrupt or a DMA request. It also exports sticky overflow and underflow flags. Changing a lane's direction flushes that lane.

Top module: `dual_byte_fifo`

## Requirements
- R1: After reset every lane is empty, not full, inbound (direction 0), with overflow and underflow clear, its request flag at 1, and all read-data outputs at 0.
- R2: With direction 0 (inbound), a bus write with `bus_sel_i` = k appends `bus_wdata_i` to lane k. A datapath read of lane k then returns bytes in write order on `dp_rdataK_o`, one cycle after the read strobe.
- R3: With direction 1 (outbound), `dp_wr_i[k]` appends `dp_wdataK_i` to lane k. A bus read with `bus_sel_i` = k then returns bytes in write order on `bus_rdata_o`, one cycle after the strobe.
- R4: Accesses from the side that a lane's direction does not allow have no effect. This covers bus writes to an outbound lane, bus reads of an inbound lane, and datapath writes or reads against the wrong mode. Occupancy, flags and read data stay unchanged.
- R5: `full_o[k]` is 1 exactly when lane k holds DEPTH bytes, and `empty_o[k]` is 1 exactly when it holds none.
- R6: `req_o[k]` is 1 when the lane is not full in inbound mode, and when it is not empty in outbound mode.
- R7: A write to a full lane is dropped and sets `ovf_o[k]`. The flag stays set until reset or a flush of that lane.
- R8: A read from an empty lane leaves the corresponding read-data output at its last value and sets `unf_o[k]`. The flag stays set until reset or a flush.
- R9: A cycle in which `dir_i[k]` differs from the lane's current direction flushes lane k. The lane becomes empty, its sticky flags clear, and every access to it in that cycle is ignored. The new direction applies from the next cycle.
- R10: `dp_cap_i` writes `dp_wdata0_i` into lane 0 and `dp_wdata1_i` into lane 1 in the same cycle, for each lane that is outbound.
- R11: Each lane's direction, contents and flags are independent of the other lane's.
- R12: Fullness and emptiness are judged on the occupancy before the clock edge. At full, a simultaneous write and read completes the read and drops the write. At empty, a simultaneous write and read completes the write and flags underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_i | input | 2 | Per-lane direction, 0 inbound, 1 outbound |
| bus_sel_i | input | 1 | Lane selected by a bus access |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wdata_i | input | 8 | Bus write byte |
| bus_rdata_o | output | 8 | Last byte read by the bus |
| dp_wr_i | input | 2 | Datapath write strobe per lane |
| dp_rd_i | input | 2 | Datapath read strobe per lane |
| dp_cap_i | input | 1 | Capture strobe, writes both lanes |
| dp_wdata0_i | input | 8 | Datapath byte for lane 0 |
| dp_wdata1_i | input | 8 | Datapath byte for lane 1 |
| dp_rdata0_o | output | 8 | Last byte the datapath read from lane 0 |
| dp_rdata1_o | output | 8 | Last byte the datapath read from lane 1 |
| empty_o | output | 2 | Per-lane empty |
| full_o | output | 2 | Per-lane full |
| req_o | output | 2 | Per-lane service request |
| ovf_o | output | 2 | Per-lane sticky overflow |
| unf_o | output | 2 | Per-lane sticky underflow |

## Verification
Every result of this block is due one clock edge after its stimulus. Occupancy flags, request flags, sticky flags, both read-data registers and the direction change all settle on the edge that samples the strobe. The bench drives strobes on the falling edge and steps a queue-based model on the following rising edge. It compares every output on the next falling edge, so each check falls exactly one edge after its stimulus. A flush is judged on that same edge, and the access that was ignored during the flush is checked against unchanged queue contents.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
    localparam int NLANE = 2;
    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;
endpackage

// File: rtl/dfifo_lane.sv
module dfifo_lane #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
        logic                        ovf;
        logic                        unf;
    } lane_t;

    lane_t st_d, st_q;
    logic  wr_ok, rd_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_i && (st_q.cnt != CFULL);
        rd_ok = rd_i && (st_q.cnt != '0);
        if (flush_i) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
        end else begin
            if (wr_ok) begin
                st_d.mem[st_q.wp] = wdata_i;
                st_d.wp = (st_q.wp == PLAST) ? '0 : st_q.wp + 1'b1;
            end else if (wr_i) begin
                st_d.ovf = 1'b1;
            end
            if (rd_ok) begin
                st_d.rp = (st_q.rp == PLAST) ? '0 : st_q.rp + 1'b1;
            end else if (rd_i) begin
                st_d.unf = 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CFULL);
    assign ovf_o   = st_q.ovf;
    assign unf_o   = st_q.unf;

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !flush_i |=> ovf_o);
    a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && wr_i && !rd_i && !flush_i |=> full_o && ovf_o);
    a_r8_unf_on_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o && rd_i && !flush_i |=> unf_o);
    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !rd_i && !full_o && !flush_i |=> !empty_o);
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o && !ovf_o && !unf_o);
endmodule

// File: rtl/dfifo_route.sv
module dfifo_route #(
    parameter int WIDTH = 8
) (
    input  logic             dir_i,
    input  logic             flush_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [WIDTH-1:0] bus_wdata_i,
    input  logic             dp_wr_i,
    input  logic             dp_rd_i,
    input  logic [WIDTH-1:0] dp_wdata_i,
    input  logic             empty_i,
    input  logic             full_i,
    output logic             lane_wr_o,
    output logic             lane_rd_o,
    output logic [WIDTH-1:0] lane_wdata_o,
    output logic             bus_take_o,
    output logic             dp_take_o,
    output logic             req_o
);
    import dfifo_pkg::*;

    always_comb begin
        lane_wr_o    = 1'b0;
        lane_rd_o    = 1'b0;
        lane_wdata_o = bus_wdata_i;
        bus_take_o   = 1'b0;
        dp_take_o    = 1'b0;
        if (dir_e'(dir_i) == DIR_OUT) begin
            req_o        = !empty_i;
            lane_wdata_o = dp_wdata_i;
            if (!flush_i) begin
                lane_wr_o  = dp_wr_i;
                lane_rd_o  = bus_rd_i;
                bus_take_o = bus_rd_i && !empty_i;
            end
        end else begin
            req_o = !full_i;
            if (!flush_i) begin
                lane_wr_o = bus_wr_i;
                lane_rd_o = dp_rd_i;
                dp_take_o = dp_rd_i && !empty_i;
            end
        end
    end
endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       dir_i,
    input  logic             bus_sel_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [WIDTH-1:0] bus_wdata_i,
    output logic [WIDTH-1:0] bus_rdata_o,
    input  logic [1:0]       dp_wr_i,
    input  logic [1:0]       dp_rd_i,
    input  logic             dp_cap_i,
    input  logic [WIDTH-1:0] dp_wdata0_i,
    input  logic [WIDTH-1:0] dp_wdata1_i,
    output logic [WIDTH-1:0] dp_rdata0_o,
    output logic [WIDTH-1:0] dp_rdata1_o,
    output logic [1:0]       empty_o,
    output logic [1:0]       full_o,
    output logic [1:0]       req_o,
    output logic [1:0]       ovf_o,
    output logic [1:0]       unf_o
);
    import dfifo_pkg::*;

    typedef struct packed {
        logic [NLANE-1:0]            dir;
        logic [WIDTH-1:0]            bus_rdata;
        logic [NLANE-1:0][WIDTH-1:0] dp_rdata;
    } top_t;

    top_t st_d, st_q;

    logic [NLANE-1:0][WIDTH-1:0] dp_wdata, lane_wdata, head;
    logic [NLANE-1:0] flush, lane_wr, lane_rd, bus_take, dp_take;

    assign dp_wdata = {dp_wdata1_i, dp_wdata0_i};

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic bus_hit;
        assign bus_hit  = (bus_sel_i == k[0]);
        assign flush[k] = (dir_i[k] != st_q.dir[k]);

        dfifo_route #(.WIDTH(WIDTH)) u_route (
            .dir_i        (st_q.dir[k]),
            .flush_i      (flush[k]),
            .bus_wr_i     (bus_wr_i && bus_hit),
            .bus_rd_i     (bus_rd_i && bus_hit),
            .bus_wdata_i  (bus_wdata_i),
            .dp_wr_i      (dp_wr_i[k] || dp_cap_i),
            .dp_rd_i      (dp_rd_i[k]),
            .dp_wdata_i   (dp_wdata[k]),
            .empty_i      (empty_o[k]),
            .full_i       (full_o[k]),
            .lane_wr_o    (lane_wr[k]),
            .lane_rd_o    (lane_rd[k]),
            .lane_wdata_o (lane_wdata[k]),
            .bus_take_o   (bus_take[k]),
            .dp_take_o    (dp_take[k]),
            .req_o        (req_o[k])
        );

        dfifo_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush[k]),
            .wr_i    (lane_wr[k]),
            .wdata_i (lane_wdata[k]),
            .rd_i    (lane_rd[k]),
            .head_o  (head[k]),
            .empty_o (empty_o[k]),
            .full_o  (full_o[k]),
            .ovf_o   (ovf_o[k]),
            .unf_o   (unf_o[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.dir = dir_i;
        for (int k = 0; k < NLANE; k++) begin
            if (bus_take[k]) st_d.bus_rdata   = head[k];
            if (dp_take[k])  st_d.dp_rdata[k] = head[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o = st_q.bus_rdata;
    assign dp_rdata0_o = st_q.dp_rdata[0];
    assign dp_rdata1_o = st_q.dp_rdata[1];

    a_r3_bus_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
    a_r4_bus_wr_outbound_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && !dp_cap_i && dp_wr_i == 2'b00 && dp_rd_i == 2'b00 && !bus_rd_i
        && st_q.dir[bus_sel_i] && !flush[bus_sel_i]
        |=> $stable(empty_o) && $stable(full_o));
    a_r10_capture_both: assert property (@(posedge clk) disable iff (!rst_n)
        dp_cap_i && st_q.dir == 2'b11 && flush == 2'b00 && full_o == 2'b00 && !bus_rd_i
        |=> empty_o == 2'b00);
    a_r8_dp_rdata_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o[0] && dp_rd_i[0] |=> $stable(dp_rdata0_o));
endmodule

// File: tb/sim_dual_byte_fifo.sv
module sim_dual_byte_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dir_i = 2'b00;
    logic       bus_sel_i = 1'b0, bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [7:0] bus_wdata_i = '0, bus_rdata_o;
    logic [1:0] dp_wr_i = '0, dp_rd_i = '0;
    logic       dp_cap_i = 1'b0;
    logic [7:0] dp_wdata0_i = '0, dp_wdata1_i = '0, dp_rdata0_o, dp_rdata1_o;
    logic [1:0] empty_o, full_o, req_o, ovf_o, unf_o;

    always #5ns clk = ~clk;

    dual_byte_fifo u0 (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .bus_sel_i(bus_sel_i),
        .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .dp_wr_i(dp_wr_i), .dp_rd_i(dp_rd_i),
        .dp_cap_i(dp_cap_i), .dp_wdata0_i(dp_wdata0_i), .dp_wdata1_i(dp_wdata1_i),
        .dp_rdata0_o(dp_rdata0_o), .dp_rdata1_o(dp_rdata1_o), .empty_o(empty_o),
        .full_o(full_o), .req_o(req_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    int    n_run = 0, n_fail = 0;
    string tag = "R1";

    logic [7:0] mq [2][$];
    logic [1:0] mdir = 2'b00, movf = 2'b00, munf = 2'b00;
    logic [7:0] mbus = '0;
    logic [7:0] mdp [2];

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [1:0] e, f, r;
        for (int k = 0; k < 2; k++) begin
            e[k] = (mq[k].size() == 0);
            f[k] = (mq[k].size() == 4);
            r[k] = mdir[k] ? !e[k] : !f[k];
        end
        chk("empty", {6'b0, empty_o}, {6'b0, e});
        chk("full",  {6'b0, full_o},  {6'b0, f});
        chk("req",   {6'b0, req_o},   {6'b0, r});
        chk("ovf",   {6'b0, ovf_o},   {6'b0, movf});
        chk("unf",   {6'b0, unf_o},   {6'b0, munf});
        chk("bus_rdata", bus_rdata_o, mbus);
        chk("dp_rdata0", dp_rdata0_o, mdp[0]);
        chk("dp_rdata1", dp_rdata1_o, mdp[1]);
    endtask

    task automatic model_step();
        for (int k = 0; k < 2; k++) begin
            logic       wr, rd;
            logic [7:0] wd;
            int         sz;
            if (dir_i[k] != mdir[k]) begin
                mq[k].delete();
                movf[k] = 1'b0;
                munf[k] = 1'b0;
                mdir[k] = dir_i[k];
                continue;
            end
            if (mdir[k]) begin
                wr = dp_wr_i[k] || dp_cap_i;
                wd = (k == 0) ? dp_wdata0_i : dp_wdata1_i;
                rd = bus_rd_i && (bus_sel_i == k[0]);
            end else begin
                wr = bus_wr_i && (bus_sel_i == k[0]);
                wd = bus_wdata_i;
                rd = dp_rd_i[k];
            end
            sz = mq[k].size();
            if (rd) begin
                if (sz == 0) munf[k] = 1'b1;
                else begin
                    if (mdir[k]) mbus = mq[k].pop_front();
                    else         mdp[k] = mq[k].pop_front();
                end
            end
            if (wr) begin
                if (sz == 4) movf[k] = 1'b1;
                else mq[k].push_back(wd);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
        bus_wr_i = 1'b0; bus_rd_i = 1'b0; dp_wr_i = '0; dp_rd_i = '0; dp_cap_i = 1'b0;
    endtask

    task automatic bus_wr(logic s, logic [7:0] d);
        bus_sel_i = s; bus_wr_i = 1'b1; bus_wdata_i = d; tick();
    endtask
    task automatic bus_rd(logic s);
        bus_sel_i = s; bus_rd_i = 1'b1; tick();
    endtask
    task automatic dp_rd(int k);
        dp_rd_i[k] = 1'b1; tick();
    endtask
    task automatic dp_wr(int k, logic [7:0] d);
        dp_wr_i[k] = 1'b1;
        if (k == 0) dp_wdata0_i = d; else dp_wdata1_i = d;
        tick();
    endtask

    initial begin
        #200us;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mdp[0] = '0; mdp[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; check_all();

        tag = "R2";
        bus_wr(0, 8'h11); bus_wr(0, 8'h22); bus_wr(0, 8'h33);
        dp_rd(0); dp_rd(0); dp_rd(0);

        tag = "R9"; dir_i[1] = 1'b1; bus_sel_i = 1'b1; bus_wr_i = 1'b1; tick();
        tag = "R3";
        dp_wr(1, 8'hA1); dp_wr(1, 8'hA2); bus_rd(1); bus_rd(1);

        tag = "R4";
        dp_wr(1, 8'h55); bus_wr(1, 8'h66); dp_rd(1); dp_wr(0, 8'h77);
        bus_rd(0); bus_rd(1);

        tag = "R5";
        for (int i = 0; i < 4; i++) bus_wr(0, 8'h40 + 8'(i));
        tag = "R7"; bus_wr(0, 8'hEE); bus_wr(0, 8'hEF);
        tag = "R12"; bus_sel_i = 0; bus_wr_i = 1; bus_wdata_i = 8'hF0; dp_rd_i[0] = 1; tick();
        tag = "R8";
        for (int i = 0; i < 4; i++) dp_rd(0);
        dp_rd(0);
        tag = "R12"; bus_sel_i = 0; bus_wr_i = 1; bus_wdata_i = 8'hF1; dp_rd_i[0] = 1; tick();
        tag = "R9"; dir_i[0] = 1'b1; dp_wr_i[0] = 1'b1; tick(); tick();

        tag = "R10";
        dp_cap_i = 1; dp_wdata0_i = 8'hC0; dp_wdata1_i = 8'hC1; tick();
        dp_cap_i = 1; dp_wdata0_i = 8'hD0; dp_wdata1_i = 8'hD1; tick();
        bus_rd(0); bus_rd(1); bus_rd(1); bus_rd(0);

        tag = "R6"; dir_i = 2'b00; tick();
        for (int i = 0; i < 4; i++) bus_wr(1, 8'h90 + 8'(i));

        tag = "R11";
        for (int i = 0; i < 2000; i++) begin
            if (($urandom % 64) == 0) dir_i[$urandom % 2] ^= 1'b1;
            bus_sel_i = 1'($urandom); bus_wr_i = 1'($urandom); bus_rd_i = 1'($urandom);
            bus_wdata_i = 8'($urandom); dp_wr_i = 2'($urandom); dp_rd_i = 2'($urandom);
            dp_cap_i = (($urandom % 8) == 0);
            dp_wdata0_i = 8'($urandom); dp_wdata1_i = 8'($urandom);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule